// File: doc/BRIEF.md
# Multi-port cell bus transmit controller

This block is the cell-source side of a shared multi-port transmit bus. Several PHY ports sit on one set of address, enable, start-of-cell, data and parity lines. The controller keeps polling the port addresses and records the cell-available answer of each port. It picks a port that is ready and that has a cell waiting in the local cell store. It then selects that port and sends the whole cell as 8-bit bytes or as 16-bit words. A static configuration input chooses the width.

Polling does not depend on the transfer. It goes on while cell data moves, and it stops only in the one cycle in which a port address selects a port. A transfer can be held off for any number of cycles through a hold input. The controller resumes it by driving the address of the same port again before it re-enables the bus. The cell store is read combinationally through a port number and a byte index. It returns the byte at that index and the byte after it, so that a 16-bit word can be built in one cycle.

Top module: `cellbus_tx_master`

## Requirements
- R1: While reset is low and after it is released, and until the first active clock edge, `phy_addr` is the null address 31, `phy_enb_n` is 1 and `phy_soc` is 0.
- R2: With nothing to send, `phy_addr` steps through the poll addresses 0, 1, ..., N_PORTS-1 and wraps, one address per cycle, starting at 0 on the first edge after reset. A port is served only if its latest poll answer on `phy_clav` was 1, and a port that answers 0 keeps its pending cell.
- R3: Polling continues while data is transferred, so every port address appears on `phy_addr` during the enabled cycles of each cell.
- R4: A port is selected by driving its address in the cycle just before `phy_enb_n` goes low. After a pause, the cell's own port address is driven in the cycle before enable returns, and `phy_soc` stays 0.
- R5: `phy_soc` is 1 with the first transfer of a cell only. No new cell starts before the current one is complete. `cb_done` is 1 during the last transfer of each cell.
- R6: With `cfg_wide`=0 a cell is 53 transfers. Transfer i carries cell byte i on `phy_data[7:0]`, and `phy_data[15:8]` is 0.
- R7: With `cfg_wide`=1 a cell is 27 words. The 53 cell bytes are sent as a 54-byte stream in which a 0x00 filler follows the 5 header bytes. The earlier stream byte of each word is on `phy_data[15:8]`.
- R8: `phy_par` gives odd parity over the active data bits. The unused upper byte is 0 in 8-bit mode.
- R9: If `tx_hold` is 1 at an edge after a non-final transfer, enable goes high in the next cycle. While `tx_hold` is 0, enable stays low until the cell ends. `tx_hold` has no effect in a selection cycle.
- R10: The next port is the first eligible one (ready and pending) after the last port served, in rising circular order.
- R11: The store is read with `cb_port` and `cb_idx`. It answers combinationally, with byte `cb_idx` on `cb_byte0` and byte `cb_idx`+1 on `cb_byte1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_wide | input | 1 | 1 selects 16-bit words, 0 selects bytes; changed only while idle |
| tx_hold | input | 1 | Requests a pause of the running transfer |
| phy_clav | input | 1 | Cell-available answer for the address polled two edges earlier |
| cb_pending | input | N_PORTS | One bit per port: a cell is waiting in the store |
| cb_byte0 | input | 8 | Store byte at `cb_idx` |
| cb_byte1 | input | 8 | Store byte at `cb_idx`+1 |
| phy_addr | output | 5 | Poll or selection address, 31 = null |
| phy_enb_n | output | 1 | Transfer enable, active low |
| phy_soc | output | 1 | Start of cell, with the first transfer |
| phy_data | output | 16 | Cell data |
| phy_par | output | 1 | Odd parity of `phy_data` |
| cb_port | output | 5 | Port whose cell is being read |
| cb_idx | output | 6 | Byte index into that cell |
| cb_done | output | 1 | Last transfer of the cell is on the bus |

## Verification
The assertions assume that `cfg_wide` changes only while no cell is in progress, because the word counter that checks start-of-cell placement takes its cell length from the present mode. They also assume that reset is held for at least one edge before they are evaluated. The bench changes the width only after every loaded cell has been sent and the store is empty, and it holds reset for several cycles at the start. The PHY model answers cell-available as a register of the sampled address. The store model lowers a port's pending bit when `cb_done` is seen, which matches the timing the controller expects.

// File: rtl/cellbus_tx_pkg.sv
// Shared types and helpers for the cell bus transmit controller.
// Assumes: data lanes are 16 bits wide; unused lanes are driven to zero.
package cellbus_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SELECT = 2'd1,
        ST_SEND   = 2'd2,
        ST_PAUSE  = 2'd3
    } tx_state_e;

    // Odd parity bit: total number of ones in {data, parity} is odd.
    function automatic logic odd_parity16(input logic [15:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/cellbus_poller.sv
// Poll address generator and cell-available scoreboard.
// Walks the poll index over 0..N_PORTS-1 each time the top takes a poll
// slot. The answer to an address comes back two edges after the address
// is loaded onto the bus: one edge for the PHY to sample it and one for
// this block to sample the answer.
// Assumes: take and clr are never both set for the cycle of one address.
module cellbus_poller #(
    parameter int N_PORTS = 4,
    parameter int PW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take,
    input  logic               clav,
    input  logic               clr,
    input  logic [PW-1:0]      clr_idx,
    output logic [PW-1:0]      poll_idx,
    output logic [N_PORTS-1:0] ready
);

    logic [PW-1:0] ptr_q;
    logic          s1_vld_q, s2_vld_q;
    logic [PW-1:0] s1_idx_q, s2_idx_q;

    // Advance the poll pointer with wrap at the last port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (take) begin
            ptr_q <= (ptr_q == PW'(N_PORTS - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    // Follow each polled address until its answer is due.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld_q <= 1'b0;
            s2_vld_q <= 1'b0;
            s1_idx_q <= '0;
            s2_idx_q <= '0;
        end else begin
            s1_vld_q <= take;
            s1_idx_q <= ptr_q;
            s2_vld_q <= s1_vld_q;
            s2_idx_q <= s1_idx_q;
        end
    end

    // Store the latest answer per port; a pick clears it (clear wins).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= '0;
        end else begin
            for (int p = 0; p < N_PORTS; p++) begin
                if (clr && clr_idx == PW'(p)) begin
                    ready[p] <= 1'b0;
                end else if (s2_vld_q && s2_idx_q == PW'(p)) begin
                    ready[p] <= clav;
                end
            end
        end
    end

    assign poll_idx = ptr_q;

endmodule

// File: rtl/cellbus_rr.sv
// Round-robin port chooser.
// Grants the first requesting port after the last granted one, in rising
// circular order. The pointer moves only when the grant is used (adv).
// Assumes: req is stable within the cycle it is used.
module cellbus_rr #(
    parameter int N_PORTS = 4,
    parameter int PW      = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_PORTS-1:0] req,
    input  logic               adv,
    output logic               gnt_vld,
    output logic [PW-1:0]      gnt_idx
);

    logic [PW-1:0] last_q;

    // Scan from the port after the last grant and keep the first hit.
    always_comb begin
        gnt_vld = 1'b0;
        gnt_idx = '0;
        for (int s = 1; s <= N_PORTS; s++) begin
            int cand;
            cand = (int'(last_q) + s) % N_PORTS;
            if (!gnt_vld && req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = PW'(cand);
            end
        end
    end

    // Remember the port that was granted last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= PW'(N_PORTS - 1);
        end else if (adv && gnt_vld) begin
            last_q <= gnt_idx;
        end
    end

endmodule

// File: rtl/cellbus_word_fmt.sv
// Maps a transfer count onto a cell store index and builds the bus word.
// Byte mode: transfer k carries cell byte k in the low lane.
// Word mode: the bytes form a stream with one zero filler after the header,
// and the earlier stream byte of each pair goes in the high lane.
// Assumes: HDR_BYTES is odd, so the filler is the low byte of one word.
module cellbus_word_fmt
    import cellbus_tx_pkg::*;
#(
    parameter int HDR_BYTES = 5,
    parameter int CNT_W     = 6
) (
    input  logic             wide,
    input  logic [CNT_W-1:0] cnt,
    input  logic [7:0]       b0,
    input  logic [7:0]       b1,
    output logic [CNT_W-1:0] idx,
    output logic [15:0]      word,
    output logic             par
);

    localparam int FILL_W = (HDR_BYTES - 1) / 2;

    logic [CNT_W:0] twice;

    assign twice = {cnt, 1'b0};

    // Pick the store index and assemble lanes for the present transfer.
    always_comb begin
        if (!wide) begin
            idx  = cnt;
            word = {8'h00, b0};
        end else if (cnt < CNT_W'(FILL_W)) begin
            idx  = CNT_W'(twice);
            word = {b0, b1};
        end else if (cnt == CNT_W'(FILL_W)) begin
            idx  = CNT_W'(twice);
            word = {b0, 8'h00};
        end else begin
            idx  = CNT_W'(twice - (CNT_W + 1)'(1));
            word = {b0, b1};
        end
        par = odd_parity16(word);
    end

endmodule

// File: rtl/cellbus_tx_master.sv
// Transmit controller for a multi-port cell bus.
// Polls ports, chooses a ready port with a pending cell round-robin,
// selects it with one address cycle and sends the cell with enable low.
// Polling uses every address slot except the selection cycles. A hold
// request pauses the transfer; resuming drives the same port address again.
// Assumes: cfg_wide changes only while idle; the cell store answers within
// the cycle; N_PORTS is at most 31 so that address 31 stays the null code.
module cellbus_tx_master
    import cellbus_tx_pkg::*;
#(
    parameter int N_PORTS   = 4,
    parameter int ADDR_W    = 5,
    parameter int HDR_BYTES = 5,
    parameter int PAY_BYTES = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_wide,
    input  logic               tx_hold,
    input  logic               phy_clav,
    input  logic [N_PORTS-1:0] cb_pending,
    input  logic [7:0]         cb_byte0,
    input  logic [7:0]         cb_byte1,
    output logic [ADDR_W-1:0]  phy_addr,
    output logic               phy_enb_n,
    output logic               phy_soc,
    output logic [15:0]        phy_data,
    output logic               phy_par,
    output logic [ADDR_W-1:0]  cb_port,
    output logic [$clog2(HDR_BYTES+PAY_BYTES+1)-1:0] cb_idx,
    output logic               cb_done
);

    localparam int CELL_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int WORDS_WIDE = (CELL_BYTES + 1) / 2;
    localparam int CNT_W      = $clog2(CELL_BYTES + 1);
    localparam int PW         = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;
    localparam logic [ADDR_W-1:0] NULL_ADDR = '1;

    tx_state_e        state_q, nxt_state;
    logic [PW-1:0]    port_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cell_len;
    logic             last_word;
    logic             do_poll, do_send, do_pick, do_resel;

    logic [PW-1:0]      poll_idx;
    logic [N_PORTS-1:0] ready;
    logic               gnt_vld;
    logic [PW-1:0]      gnt_idx;
    logic [CNT_W-1:0]   fmt_idx;
    logic [15:0]        fmt_word;
    logic               fmt_par;

    cellbus_poller #(.N_PORTS(N_PORTS), .PW(PW)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (do_poll),
        .clav     (phy_clav),
        .clr      (do_pick),
        .clr_idx  (gnt_idx),
        .poll_idx (poll_idx),
        .ready    (ready)
    );

    cellbus_rr #(.N_PORTS(N_PORTS), .PW(PW)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (ready & cb_pending),
        .adv     (do_pick),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    cellbus_word_fmt #(.HDR_BYTES(HDR_BYTES), .CNT_W(CNT_W)) u_fmt (
        .wide (cfg_wide),
        .cnt  (cnt_q),
        .b0   (cb_byte0),
        .b1   (cb_byte1),
        .idx  (fmt_idx),
        .word (fmt_word),
        .par  (fmt_par)
    );

    assign cell_len  = cfg_wide ? CNT_W'(WORDS_WIDE) : CNT_W'(CELL_BYTES);
    assign last_word = (state_q == ST_SEND) && (cnt_q == cell_len);
    assign cb_done   = last_word;
    assign cb_port   = ADDR_W'(port_q);
    assign cb_idx    = fmt_idx;

    // Decide this cycle's use of the address slot and the data slot.
    always_comb begin
        nxt_state = state_q;
        do_poll   = 1'b0;
        do_send   = 1'b0;
        do_pick   = 1'b0;
        do_resel  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (gnt_vld) begin
                    do_pick   = 1'b1;
                    nxt_state = ST_SELECT;
                end else begin
                    do_poll = 1'b1;
                end
            end
            ST_SELECT: begin
                do_send   = 1'b1;
                do_poll   = 1'b1;
                nxt_state = ST_SEND;
            end
            ST_SEND: begin
                if (last_word) begin
                    if (gnt_vld) begin
                        do_pick   = 1'b1;
                        nxt_state = ST_SELECT;
                    end else begin
                        do_poll   = 1'b1;
                        nxt_state = ST_IDLE;
                    end
                end else if (tx_hold) begin
                    do_poll   = 1'b1;
                    nxt_state = ST_PAUSE;
                end else begin
                    do_send = 1'b1;
                    do_poll = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (!tx_hold) begin
                    do_resel  = 1'b1;
                    nxt_state = ST_SELECT;
                end else begin
                    do_poll = 1'b1;
                end
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    // Sequence state, the cell port and the transfer counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            port_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= nxt_state;
            if (do_pick) begin
                port_q <= gnt_idx;
                cnt_q  <= '0;
            end else if (do_send) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // Drive the address lines: selection wins over polling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_addr <= NULL_ADDR;
        end else if (do_pick) begin
            phy_addr <= ADDR_W'(gnt_idx);
        end else if (do_resel) begin
            phy_addr <= ADDR_W'(port_q);
        end else if (do_poll) begin
            phy_addr <= ADDR_W'(poll_idx);
        end
    end

    // Drive enable, start-of-cell, data and parity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phy_enb_n <= 1'b1;
            phy_soc   <= 1'b0;
            phy_data  <= '0;
            phy_par   <= 1'b1;
        end else begin
            phy_enb_n <= ~do_send;
            phy_soc   <= do_send && (cnt_q == '0);
            if (do_send) begin
                phy_data <= fmt_word;
                phy_par  <= fmt_par;
            end
        end
    end

endmodule

// File: rtl/cellbus_tx_checker.sv
// Protocol checker attached to the transmit controller by bind.
// Counts transfers per cell on the bus and follows the selected port.
// Assumes: cfg_wide changes only between cells.
module cellbus_tx_checker #(
    parameter int N_PORTS   = 4,
    parameter int ADDR_W    = 5,
    parameter int HDR_BYTES = 5,
    parameter int PAY_BYTES = 48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wide,
    input logic [ADDR_W-1:0] phy_addr,
    input logic              phy_enb_n,
    input logic              phy_soc,
    input logic [15:0]       phy_data,
    input logic              phy_par
);

    localparam int CELL_BYTES = HDR_BYTES + PAY_BYTES;
    localparam int CNT_W      = $clog2(CELL_BYTES + 1);

    logic [CNT_W-1:0]  words_q;
    logic [CNT_W-1:0]  len;
    logic [ADDR_W-1:0] prev_addr_q;
    logic [ADDR_W-1:0] cell_port_q;

    assign len = cfg_wide ? CNT_W'((CELL_BYTES + 1) / 2) : CNT_W'(CELL_BYTES);

    // Track position in the cell, previous address and the cell's port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q     <= '0;
            prev_addr_q <= '1;
            cell_port_q <= '1;
        end else begin
            prev_addr_q <= phy_addr;
            if (!phy_enb_n) begin
                words_q <= (words_q + 1'b1 == len) ? '0 : words_q + 1'b1;
                if (phy_soc) begin
                    cell_port_q <= prev_addr_q;
                end
            end
        end
    end

    // R4: enable falls only after a real port address.
    a_r4_select_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(phy_enb_n) |-> (prev_addr_q < ADDR_W'(N_PORTS)));

    // R4: a resumed transfer is preceded by the cell's own port address.
    a_r4_resume_same_port: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(phy_enb_n) && !phy_soc) |-> (prev_addr_q == cell_port_q));

    // R5: start-of-cell exactly at the first transfer of a cell.
    a_r5_soc_first_only: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_enb_n |-> (phy_soc == (words_q == '0)));

    // R8: odd parity over the data lanes.
    a_r8_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_enb_n |-> (^{phy_data, phy_par}) == 1'b1);

    // R6: upper lane idle in byte mode.
    a_r6_upper_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_enb_n && !cfg_wide) |-> (phy_data[15:8] == 8'h00));

    // R5: start-of-cell never shows without enable.
    a_r5_soc_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        phy_soc |-> !phy_enb_n);

endmodule

bind cellbus_tx_master cellbus_tx_checker #(
    .N_PORTS   (N_PORTS),
    .ADDR_W    (ADDR_W),
    .HDR_BYTES (HDR_BYTES),
    .PAY_BYTES (PAY_BYTES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wide  (cfg_wide),
    .phy_addr  (phy_addr),
    .phy_enb_n (phy_enb_n),
    .phy_soc   (phy_soc),
    .phy_data  (phy_data),
    .phy_par   (phy_par)
);

// File: tb/cellbus_tx_master_bench.sv
`timescale 1ns/1ps
module cellbus_tx_master_bench;

    localparam int NP = 4;
    localparam int AW = 5;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wide = 1'b0;
    logic          tx_hold = 1'b0;
    logic          phy_clav = 1'b0;
    logic [NP-1:0] cb_pending;
    logic [7:0]    cb_byte0, cb_byte1;
    logic [AW-1:0] phy_addr;
    logic          phy_enb_n, phy_soc, phy_par, cb_done;
    logic [15:0]   phy_data;
    logic [AW-1:0] cb_port;
    logic [CW-1:0] cb_idx;

    cellbus_tx_master u_cellbus_tx_master (
        .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .tx_hold(tx_hold),
        .phy_clav(phy_clav), .cb_pending(cb_pending), .cb_byte0(cb_byte0),
        .cb_byte1(cb_byte1), .phy_addr(phy_addr), .phy_enb_n(phy_enb_n),
        .phy_soc(phy_soc), .phy_data(phy_data), .phy_par(phy_par),
        .cb_port(cb_port), .cb_idx(cb_idx), .cb_done(cb_done)
    );

    always #2.5 clk = ~clk;

    int            vec_n = 0;
    int            err_n = 0;
    int            cyc = 0;
    int            pend [NP];
    logic [NP-1:0] rdy_mask = '0;

    function automatic logic [7:0] cbyte(input int p, input int i);
        return 8'(p * 37 + i * 5 + 1);
    endfunction

    // Expected bus word from the 54-byte stream view (R6, R7).
    function automatic logic [15:0] exp_word(input int p, input int k, input logic w);
        logic [7:0] hi, lo;
        int j;
        if (!w) return {8'h00, cbyte(p, k)};
        j  = 2 * k;
        hi = (j < 5) ? cbyte(p, j) : (j == 5) ? 8'h00 : cbyte(p, j - 1);
        j  = j + 1;
        lo = (j < 5) ? cbyte(p, j) : (j == 5) ? 8'h00 : cbyte(p, j - 1);
        return {hi, lo};
    endfunction

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        vec_n++;
        if (!ok) begin
            err_n++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // PHY model: registered cell-available answer for the sampled address.
    always @(posedge clk)
        phy_clav <= (int'(phy_addr) < NP) ? rdy_mask[phy_addr[1:0]] : 1'b0;

    // Cell store model (R11): combinational two-byte read.
    always_comb begin
        cb_byte0 = cbyte(int'(cb_port), int'(cb_idx));
        cb_byte1 = cbyte(int'(cb_port), int'(cb_idx) + 1);
        for (int p = 0; p < NP; p++) cb_pending[p] = (pend[p] > 0);
    end

    // Monitor state.
    bit            mon_on = 0;
    bit            in_cell = 0;
    int            cport = 0;
    int            widx = 0;
    logic [AW-1:0] prev_addr = '1;
    logic          prev_enb = 1'b1;
    logic          hold_seen = 1'b0;
    logic [NP-1:0] seen = '0;
    int            order [64];
    int            order_n = 0;

    always @(posedge clk) hold_seen <= tx_hold;

    always @(negedge clk) begin
        int len;
        len = cfg_wide ? 27 : 53;
        if (mon_on) begin
            if (!prev_enb && in_cell) begin
                if (hold_seen) chk("R9 pause releases enable", phy_enb_n == 1'b1, phy_enb_n, 1);
                else           chk("R9 no gap without hold", phy_enb_n == 1'b0, phy_enb_n, 0);
            end
            if (!phy_enb_n) begin
                if (phy_soc) begin
                    chk("R5 new cell only after complete cell", !in_cell, in_cell, 0);
                    chk("R2 selected address is a port", int'(prev_addr) < NP, prev_addr, 0);
                    in_cell = 1;
                    cport   = int'(prev_addr);
                    widx    = 0;
                    seen    = '0;
                    if (order_n < 64) order[order_n] = cport;
                    order_n++;
                end else begin
                    chk("R5 transfer without start of cell", in_cell, in_cell, 1);
                    if (prev_enb) chk("R4 resume address", int'(prev_addr) == cport, prev_addr, cport);
                end
                if (in_cell) begin
                    chk(cfg_wide ? "R7 word data" : "R6 byte data",
                        phy_data == exp_word(cport, widx, cfg_wide),
                        phy_data, exp_word(cport, widx, cfg_wide));
                    chk("R8 odd parity", (^{phy_data, phy_par}) == 1'b1, {phy_data, phy_par}, 0);
                    if (int'(phy_addr) < NP) seen[phy_addr[1:0]] = 1'b1;
                    widx++;
                    chk("R5 done on last transfer", cb_done == (widx == len), cb_done, widx == len);
                    if (widx == len) begin
                        in_cell = 0;
                        chk("R3 polling during transfer", seen == '1, seen, 4'hf);
                    end
                end
            end
            if (cb_done && pend[int'(cb_port) % NP] > 0) pend[int'(cb_port) % NP]--;
            prev_addr = phy_addr;
            prev_enb  = phy_enb_n;
        end
    end

    int exp_last = NP - 1;

    // One scenario: load cells, predict the round-robin order, compare (R10, R2).
    task automatic scen(input logic wide, input logic [NP-1:0] mask,
                        input int c0, input int c1, input int c2, input int c3,
                        input bit hold_en);
        int orig [NP];
        int c [NP];
        int eo [64];
        int en;
        int ptr;
        int k;
        bit found;
        orig = '{c0, c1, c2, c3};
        c    = orig;
        en   = 0;
        @(negedge clk);
        cfg_wide = wide;
        rdy_mask = mask;
        repeat (20) @(negedge clk);
        ptr = exp_last;
        do begin
            found = 0;
            for (int s = 1; s <= NP; s++) begin
                int q;
                q = (ptr + s) % NP;
                if (!found && c[q] > 0 && mask[q]) begin
                    found  = 1;
                    eo[en] = q;
                    en++;
                    c[q]--;
                    ptr = q;
                end
            end
        end while (found);
        exp_last = ptr;
        order_n  = 0;
        for (int p = 0; p < NP; p++) pend[p] = orig[p];
        k = 0;
        do begin
            @(negedge clk);
            tx_hold = hold_en && ((k % 11) < 3);
            k++;
        end while (order_n < en || in_cell);
        tx_hold = 1'b0;
        repeat (10) @(negedge clk);
        chk("R10 cell count", order_n == en, order_n, en);
        for (int i = 0; i < en; i++)
            chk("R10 round-robin order", order[i] == eo[i], order[i], eo[i]);
        for (int p = 0; p < NP; p++)
            chk("R2 only ready ports served", pend[p] == (mask[p] ? 0 : orig[p]),
                pend[p], mask[p] ? 0 : orig[p]);
        for (int p = 0; p < NP; p++) pend[p] = 0;
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            err_n++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) pend[p] = 0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 null address in reset", phy_addr == 5'd31, phy_addr, 31);
        chk("R1 enable inactive in reset", phy_enb_n == 1'b1, phy_enb_n, 1);
        chk("R1 no start of cell in reset", phy_soc == 1'b0, phy_soc, 0);
        rst_n = 1'b1;
        chk("R1 null address after release", phy_addr == 5'd31, phy_addr, 31);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk("R2 idle poll sequence", int'(phy_addr) == k % NP, phy_addr, k % NP);
            chk("R2 enable stays high while idle", phy_enb_n == 1'b1, phy_enb_n, 1);
        end
        mon_on = 1;
        for (int w = 0; w < 2; w++) begin
            scen(w[0], 4'b1111, 2, 2, 2, 2, 0);
            scen(w[0], 4'b1111, 0, 2, 0, 2, 0);
            scen(w[0], 4'b1011, 1, 1, 1, 1, 0);
            scen(w[0], 4'b1111, 0, 0, 1, 0, 0);
            scen(w[0], 4'b1111, 1, 1, 1, 1, 1);
            scen(w[0], 4'b0110, 2, 1, 2, 1, 1);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, err_n);
        $finish;
    end

endmodule